// File: doc/BRIEF.md
# Indirect Configuration Bus Bridge

This block gives an embedded controller a path into a host-side configuration register space. The controller never addresses that space directly. It first writes a port selector that picks either the index port or the data port. It then writes a byte through a local data register, or asks for a byte back through a control bit. Each such access becomes one cycle on an internal bus. The target of that bus answers through a request/acknowledge handshake whose latency may vary. Status bits in the control register show whether a write or a read is still in flight, and firmware polls them before it takes its next step.

The bridge also holds off host-side requests. Two lock bits refuse host access to the configuration space and to the battery-backed RAM. In addition, no configuration grant is given while a bridge cycle is outstanding. A power-good input gates every internal-bus cycle. When power is absent, a request is accepted without effect. A read in progress can be abandoned by clearing its request bit. Any data-register write that arrives while a cycle is in flight is refused and leaves a sticky error behind.

Top module: `cfg_bridge`

## Requirements
- R1: After reset every local register reads 0x00 and `ibus_req` is low.
- R2: Local byte registers sit at these offsets: 0 holds the port selector (bit 0; 0 selects the index port, 1 selects the data port), 1 holds data, 2 holds the host locks (bits 1:0), 3 is a free read/write byte, 4 holds the bridge master enable (bit 0), and 5 is control/status. In control/status, bit 0 is the path enable, bit 1 is the read request/pending flag, bit 2 is write busy, and bit 3 is the sticky error, cleared by writing 1. Unused bits and offsets 6 and 7 read 0.
- R3: A data-register write launches a cycle when the path enable and master enable are both set and power is good. `ibus_req` rises on the next cycle with `ibus_we`=1, `ibus_port` equal to the selector, and `ibus_wdata` equal to the written byte. Write busy then reads 1 until the cycle after the acknowledge.
- R4: Writing control/status with bits 0 and 1 set, while the data port is selected and master enable is set, launches a read (`ibus_we`=0, `ibus_port`=1). On acknowledge, bit 1 clears and the data register holds `ibus_rdata`.
- R5: No internal cycle starts while the path enable or the master enable is clear. A read request with the index port selected is dropped and bit 1 stays 0. A data-register write is still stored.
- R6: While `ibus_req` is high without `ibus_ack` (valid without ready), `ibus_we`, `ibus_port` and `ibus_wdata` hold steady. A write request is never withdrawn before it is acknowledged.
- R7: Writing control/status with bit 1 clear while a read is pending drops `ibus_req` on the next cycle, clears bit 1, and leaves the data register unchanged.
- R8: If the acknowledge of a read lands in the same cycle as an abort, the read completes: the data register takes `ibus_rdata`.
- R9: A data-register write while any cycle is in flight is ignored. The data register and the bus are unchanged, and the sticky error (bit 3) is set and stays set until it is cleared by writing 1.
- R10: With `pwr_good` low, a write or read request starts no cycle. The busy and pending bits stay 0, and a written data byte is still stored.
- R11: `host_cfg_gnt` follows `host_cfg_req` unless lock bit 0 is set or a bridge cycle is outstanding. `host_ram_gnt` follows `host_ram_req` unless lock bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Host-side power present; gates internal-bus cycles |
| reg_we | input | 1 | Local register write strobe |
| reg_addr | input | 3 | Local register offset |
| reg_wdata | input | 8 | Local register write byte |
| reg_rdata | output | 8 | Local register read byte (combinational from `reg_addr`) |
| ibus_req | output | 1 | Internal-bus request (valid) |
| ibus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| ibus_port | output | 1 | 0 = index port, 1 = data port |
| ibus_wdata | output | 8 | Write byte |
| ibus_ack | input | 1 | Target acknowledge (ready); the cycle ends on `ibus_req` and `ibus_ack` both high |
| ibus_rdata | input | 8 | Read byte, valid with `ibus_ack` |
| host_cfg_req | input | 1 | Host request to the configuration space |
| host_cfg_gnt | output | 1 | Host configuration grant |
| host_ram_req | input | 1 | Host request to the battery-backed RAM |
| host_ram_gnt | output | 1 | Host RAM grant |

## Verification
A read's acknowledge from the target and a firmware abort of that same read can land on one clock edge. The bench holds off its acknowledge model and then drives `ibus_ack` and the abort write to control/status in the same cycle. It judges the result by the data register holding the returned byte and by the scoreboard recording the completed read. A second coincidence is a data-register write that lands while a write is still waiting for its acknowledge. Here the bench checks that the held byte and the bus stay unchanged and that the error bit appears.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;
  localparam int OFS_SEL  = 0;
  localparam int OFS_DATA = 1;
  localparam int OFS_LOCK = 2;
  localparam int OFS_LVL  = 3;
  localparam int OFS_MEN  = 4;
  localparam int OFS_CTRL = 5;

  localparam int CB_EN    = 0;
  localparam int CB_RDREQ = 1;
  localparam int CB_WBUSY = 2;
  localparam int CB_ERR   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cfg_bridge_regs.sv
module cfg_bridge_regs
  import cfg_bridge_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy_wr,
  input  logic          busy_rd,
  input  logic          rd_done,
  input  logic [DW-1:0] rd_byte,
  output logic          start_wr,
  output logic          start_rd,
  output logic          abort_rd,
  output logic          port_sel,
  output logic [1:0]    lock,
  output logic          err_flag
);
  logic          sel_q, men_q, en_q, err_q;
  logic [1:0]    lock_q;
  logic [DW-1:0] data_q, lvl_q;
  logic          idle, hit_data, hit_ctrl;

  always_comb begin
    idle     = ~busy_wr & ~busy_rd;
    hit_data = reg_we && (reg_addr == AW'(OFS_DATA));
    hit_ctrl = reg_we && (reg_addr == AW'(OFS_CTRL));
  end

  // launch decisions; the read path takes the enable being written now
  assign start_wr = hit_data & idle & en_q & men_q;
  assign start_rd = hit_ctrl & reg_wdata[CB_RDREQ] & reg_wdata[CB_EN]
                  & men_q & sel_q & idle;
  assign abort_rd = hit_ctrl & ~reg_wdata[CB_RDREQ] & busy_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      men_q  <= 1'b0;
      en_q   <= 1'b0;
      lock_q <= '0;
      lvl_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        AW'(OFS_SEL):  sel_q  <= reg_wdata[0];
        AW'(OFS_LOCK): lock_q <= reg_wdata[1:0];
        AW'(OFS_LVL):  lvl_q  <= reg_wdata;
        AW'(OFS_MEN):  men_q  <= reg_wdata[0];
        AW'(OFS_CTRL): en_q   <= reg_wdata[CB_EN];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (hit_data && idle)      data_q <= reg_wdata;
      else if (rd_done)          data_q <= rd_byte;

      if (hit_data && !idle)     err_q <= 1'b1;
      else if (hit_ctrl && reg_wdata[CB_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFS_SEL):  reg_rdata[0]   = sel_q;
      AW'(OFS_DATA): reg_rdata      = data_q;
      AW'(OFS_LOCK): reg_rdata[1:0] = lock_q;
      AW'(OFS_LVL):  reg_rdata      = lvl_q;
      AW'(OFS_MEN):  reg_rdata[0]   = men_q;
      AW'(OFS_CTRL): begin
        reg_rdata[CB_EN]    = en_q;
        reg_rdata[CB_RDREQ] = busy_rd;
        reg_rdata[CB_WBUSY] = busy_wr;
        reg_rdata[CB_ERR]   = err_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign port_sel = sel_q;
  assign lock     = lock_q;
  assign err_flag = err_q;
endmodule

// File: rtl/cfg_bridge_seq.sv
module cfg_bridge_seq
  import cfg_bridge_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          start_wr,
  input  logic          start_rd,
  input  logic          abort_rd,
  input  logic          port_sel,
  input  logic [DW-1:0] wr_byte,
  output logic          busy_wr,
  output logic          busy_rd,
  output logic          rd_done,
  output logic [DW-1:0] rd_byte,
  output logic          ibus_req,
  output logic          ibus_we,
  output logic          ibus_port,
  output logic [DW-1:0] ibus_wdata,
  input  logic          ibus_ack,
  input  logic [DW-1:0] ibus_rdata
);
  seq_state_t    state_q;
  logic          port_q;
  logic [DW-1:0] wbyte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      port_q  <= 1'b0;
      wbyte_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (pwr_good && start_wr) begin
            state_q <= ST_WR;
            port_q  <= port_sel;
            wbyte_q <= wr_byte;
          end else if (pwr_good && start_rd) begin
            state_q <= ST_RD;
            port_q  <= port_sel;
          end
        end
        ST_WR: if (ibus_ack) state_q <= ST_IDLE;
        ST_RD: if (ibus_ack || abort_rd) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_wr    = (state_q == ST_WR);
  assign busy_rd    = (state_q == ST_RD);
  assign rd_done    = busy_rd & ibus_ack;
  assign rd_byte    = ibus_rdata;
  assign ibus_req   = busy_wr | busy_rd;
  assign ibus_we    = busy_wr;
  assign ibus_port  = port_q;
  assign ibus_wdata = wbyte_q;
endmodule

// File: rtl/cfg_bridge_arb.sv
module cfg_bridge_arb (
  input  logic       host_cfg_req,
  input  logic       host_ram_req,
  input  logic [1:0] lock,
  input  logic       bridge_busy,
  output logic       host_cfg_gnt,
  output logic       host_ram_gnt
);
  assign host_cfg_gnt = host_cfg_req & ~lock[0] & ~bridge_busy;
  assign host_ram_gnt = host_ram_req & ~lock[1];
endmodule

// File: rtl/cfg_bridge.sv
module cfg_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          ibus_req,
  output logic          ibus_we,
  output logic          ibus_port,
  output logic [DW-1:0] ibus_wdata,
  input  logic          ibus_ack,
  input  logic [DW-1:0] ibus_rdata,
  input  logic          host_cfg_req,
  output logic          host_cfg_gnt,
  input  logic          host_ram_req,
  output logic          host_ram_gnt
);
  logic          busy_wr, busy_rd, rd_done;
  logic          start_wr, start_rd, abort_rd, port_sel, err_flag;
  logic [1:0]    lock;
  logic [DW-1:0] rd_byte;

  cfg_bridge_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy_wr(busy_wr), .busy_rd(busy_rd), .rd_done(rd_done), .rd_byte(rd_byte),
    .start_wr(start_wr), .start_rd(start_rd), .abort_rd(abort_rd),
    .port_sel(port_sel), .lock(lock), .err_flag(err_flag)
  );

  cfg_bridge_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .start_wr(start_wr), .start_rd(start_rd), .abort_rd(abort_rd),
    .port_sel(port_sel), .wr_byte(reg_wdata),
    .busy_wr(busy_wr), .busy_rd(busy_rd), .rd_done(rd_done), .rd_byte(rd_byte),
    .ibus_req(ibus_req), .ibus_we(ibus_we), .ibus_port(ibus_port),
    .ibus_wdata(ibus_wdata), .ibus_ack(ibus_ack), .ibus_rdata(ibus_rdata)
  );

  cfg_bridge_arb u_arb (
    .host_cfg_req(host_cfg_req), .host_ram_req(host_ram_req), .lock(lock),
    .bridge_busy(ibus_req), .host_cfg_gnt(host_cfg_gnt), .host_ram_gnt(host_ram_gnt)
  );
endmodule

// File: rtl/cfg_bridge_chk.sv
module cfg_bridge_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_good,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          wbit_rdreq,
  input logic          wbit_err,
  input logic          ibus_req,
  input logic          ibus_we,
  input logic          ibus_port,
  input logic [DW-1:0] ibus_wdata,
  input logic          ibus_ack,
  input logic          host_cfg_req,
  input logic          host_cfg_gnt,
  input logic          host_ram_req,
  input logic          host_ram_gnt,
  input logic          busy_wr,
  input logic          busy_rd,
  input logic          err_flag
);
  // R6: request fields stay put while waiting for the target
  p_hold_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ibus_req && !ibus_ack |=> !ibus_req ||
      ($stable(ibus_we) && $stable(ibus_port) && $stable(ibus_wdata)));

  // R6: a write is never withdrawn before acknowledge
  p_write_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ibus_req && ibus_we && !ibus_ack |=> ibus_req);

  // R10: no cycle launched without power
  p_needs_power_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibus_req) |-> $past(pwr_good));

  // R7: abort drops the request on the next cycle
  p_abort_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rd && reg_we && reg_addr == AW'(5) && !wbit_rdreq && !ibus_ack
      |=> !ibus_req);

  // R9: collision with a running cycle raises the error
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_wr || busy_rd) && reg_we && reg_addr == AW'(1) |=> err_flag);

  // R9: error stays until cleared by a write of 1
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !(reg_we && reg_addr == AW'(5) && wbit_err) |=> err_flag);

  // R11: grants only answer requests, config grant never during a cycle
  p_cfg_gnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_cfg_gnt |-> host_cfg_req && !ibus_req);
  p_ram_gnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_ram_gnt |-> host_ram_req);
endmodule

bind cfg_bridge cfg_bridge_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .reg_we(reg_we),
  .reg_addr(reg_addr), .wbit_rdreq(reg_wdata[1]), .wbit_err(reg_wdata[3]),
  .ibus_req(ibus_req), .ibus_we(ibus_we), .ibus_port(ibus_port),
  .ibus_wdata(ibus_wdata), .ibus_ack(ibus_ack),
  .host_cfg_req(host_cfg_req), .host_cfg_gnt(host_cfg_gnt),
  .host_ram_req(host_ram_req), .host_ram_gnt(host_ram_gnt),
  .busy_wr(busy_wr), .busy_rd(busy_rd), .err_flag(err_flag)
);

// File: tb/cfg_bridge_tb.sv
`timescale 1ns/1ps
module cfg_bridge_tb;
  typedef struct packed {
    logic       we;
    logic       port;
    logic [7:0] data;
  } txn_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ibus_req, ibus_we, ibus_port;
  logic [7:0] ibus_wdata;
  logic       ibus_ack = 1'b0;
  logic [7:0] ibus_rdata = '0;
  logic       host_cfg_req = 1'b0, host_ram_req = 1'b0;
  logic       host_cfg_gnt, host_ram_gnt;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;
  bit   auto_ack = 1;
  int   lat = 0;
  int   wait_cnt = 0;
  logic [7:0] rd_val = '0;
  txn_t exp_q[$];

  always #10 clk = ~clk;

  cfg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ibus_req(ibus_req), .ibus_we(ibus_we), .ibus_port(ibus_port),
    .ibus_wdata(ibus_wdata), .ibus_ack(ibus_ack), .ibus_rdata(ibus_rdata),
    .host_cfg_req(host_cfg_req), .host_cfg_gnt(host_cfg_gnt),
    .host_ram_req(host_ram_req), .host_ram_gnt(host_ram_gnt)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push(input logic we, input logic port, input logic [7:0] d);
    txn_t t;
    t.we = we; t.port = port; t.data = d;
    exp_q.push_back(t);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && ibus_req; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // target model: acknowledge after lat waiting cycles
  always @(negedge clk) begin
    if (auto_ack) begin
      if (ibus_req && !ibus_ack) begin
        if (wait_cnt >= lat) begin
          ibus_ack = 1'b1;
          ibus_rdata = rd_val;
          wait_cnt = 0;
        end else wait_cnt++;
      end else ibus_ack = 1'b0;
    end
  end

  // monitor: each handshake is compared against the scoreboard queue (R3 R4 R6)
  always @(negedge clk) begin
    txn_t t;
    #2;
    if (rst_n && ibus_req && ibus_ack) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 unexpected bus cycle actual=we%0b/p%0b/%h expected=none",
                 ibus_we, ibus_port, ibus_wdata);
      end else begin
        t = exp_q.pop_front();
        if (t.we !== ibus_we || t.port !== ibus_port || (t.we && t.data !== ibus_wdata)) begin
          n_bad++;
          $display("FAIL R6 bus cycle actual=we%0b/p%0b/%h expected=we%0b/p%0b/%h",
                   ibus_we, ibus_port, ibus_wdata, t.we, t.port, t.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1 reset reg", 3'(a), 8'h00);
    chk("R1 ibus_req", {7'b0, ibus_req}, 8'h00);

    // R2 layout
    wr(3'd3, 8'hA5); rd_chk("R2 level", 3'd3, 8'hA5);
    wr(3'd0, 8'hFF); rd_chk("R2 sel", 3'd0, 8'h01);
    wr(3'd2, 8'hFF); rd_chk("R2 lock", 3'd2, 8'h03);
    wr(3'd4, 8'hFF); rd_chk("R2 men", 3'd4, 8'h01);
    wr(3'd6, 8'hFF); rd_chk("R2 offset6", 3'd6, 8'h00);
    wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd4, 8'h00);

    // R5 no cycle without enables
    wr(3'd1, 8'h11); repeat (3) @(negedge clk);
    chk("R5 no req path off", {7'b0, ibus_req}, 8'h00);
    rd_chk("R5 data stored", 3'd1, 8'h11);
    wr(3'd5, 8'h01); wr(3'd1, 8'h22); repeat (3) @(negedge clk);
    chk("R5 no req men off", {7'b0, ibus_req}, 8'h00);

    // R3 writes to index then data port
    wr(3'd4, 8'h01);
    lat = 3;
    push(1'b1, 1'b0, 8'h07);
    wr(3'd1, 8'h07);
    chk("R3 req high", {7'b0, ibus_req}, 8'h01);
    chk("R3 wdata", ibus_wdata, 8'h07);
    rd_chk("R3 busy", 3'd5, 8'h05);
    wait_idle(); @(negedge clk);
    rd_chk("R3 busy clear", 3'd5, 8'h01);
    wr(3'd0, 8'h01);
    push(1'b1, 1'b1, 8'h0C);
    wr(3'd1, 8'h0C);
    wait_idle(); @(negedge clk);

    // R9 write while busy
    lat = 5;
    push(1'b1, 1'b1, 8'h3C);
    wr(3'd1, 8'h3C);
    wr(3'd1, 8'h99);
    rd_chk("R9 data kept", 3'd1, 8'h3C);
    rd_chk("R9 err busy", 3'd5, 8'h0D);
    wait_idle(); @(negedge clk);
    rd_chk("R9 err sticky", 3'd5, 8'h09);
    wr(3'd5, 8'h09);
    rd_chk("R9 err cleared", 3'd5, 8'h01);

    // R4 read from data port
    lat = 2; rd_val = 8'h5A;
    push(1'b0, 1'b1, 8'h00);
    wr(3'd5, 8'h03);
    rd_chk("R4 pending", 3'd5, 8'h03);
    chk("R4 read cycle", {6'b0, ibus_req, ibus_we}, 8'h02);
    wait_idle(); @(negedge clk);
    rd_chk("R4 pending clear", 3'd5, 8'h01);
    rd_chk("R4 data", 3'd1, 8'h5A);
    // R5 read with index port selected is dropped
    wr(3'd0, 8'h00); wr(3'd5, 8'h03);
    rd_chk("R5 read dropped", 3'd5, 8'h01);
    chk("R5 no read req", {7'b0, ibus_req}, 8'h00);
    wr(3'd0, 8'h01);

    // R7 abort
    auto_ack = 0; ibus_ack = 1'b0;
    wr(3'd5, 8'h03);
    chk("R7 req before abort", {7'b0, ibus_req}, 8'h01);
    repeat (2) @(negedge clk);
    wr(3'd5, 8'h01);
    chk("R7 req dropped", {7'b0, ibus_req}, 8'h00);
    rd_chk("R7 pending clear", 3'd5, 8'h01);
    rd_chk("R7 data unchanged", 3'd1, 8'h5A);

    // R8 acknowledge and abort together
    push(1'b0, 1'b1, 8'h00);
    wr(3'd5, 8'h03);
    repeat (2) @(negedge clk);
    ibus_ack = 1'b1; ibus_rdata = 8'hC3;
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h01;
    @(negedge clk);
    ibus_ack = 1'b0; reg_we = 1'b0;
    chk("R8 req low", {7'b0, ibus_req}, 8'h00);
    rd_chk("R8 data captured", 3'd1, 8'hC3);
    rd_chk("R8 ctrl", 3'd5, 8'h01);
    auto_ack = 1; lat = 1;

    // R10 power absent
    pwr_good = 1'b0;
    wr(3'd1, 8'h44); repeat (2) @(negedge clk);
    chk("R10 no write req", {7'b0, ibus_req}, 8'h00);
    rd_chk("R10 ctrl idle", 3'd5, 8'h01);
    rd_chk("R10 data stored", 3'd1, 8'h44);
    wr(3'd5, 8'h03); repeat (2) @(negedge clk);
    rd_chk("R10 read not pending", 3'd5, 8'h01);
    pwr_good = 1'b1;

    // R11 host grants
    host_cfg_req = 1'b1; host_ram_req = 1'b1; #1;
    chk("R11 cfg open", {7'b0, host_cfg_gnt}, 8'h01);
    chk("R11 ram open", {7'b0, host_ram_gnt}, 8'h01);
    wr(3'd2, 8'h01); #1;
    chk("R11 cfg locked", {7'b0, host_cfg_gnt}, 8'h00);
    chk("R11 ram still open", {7'b0, host_ram_gnt}, 8'h01);
    wr(3'd2, 8'h02); #1;
    chk("R11 ram locked", {7'b0, host_ram_gnt}, 8'h00);
    chk("R11 cfg reopened", {7'b0, host_cfg_gnt}, 8'h01);
    wr(3'd2, 8'h00);
    lat = 3;
    push(1'b1, 1'b1, 8'h77);
    wr(3'd1, 8'h77); #1;
    chk("R11 cfg held by cycle", {7'b0, host_cfg_gnt}, 8'h00);
    wait_idle(); @(negedge clk); #1;
    chk("R11 cfg after cycle", {7'b0, host_cfg_gnt}, 8'h01);

    repeat (3) @(negedge clk);
    chk("R3 all expected cycles seen", 8'(exp_q.size()), 8'h00);
    done = 1;
    summary();
    $finish;
  end
endmodule